// File: doc/BRIEF.md
# Scripted AXI4-Lite Write Sequencer

The sequencer walks through a small command memory from index 0 and turns each 40-bit command into an action on an AXI4-Lite master write port. A command can set the target address, write a 32-bit value to that address, pause for a set number of clock cycles, or stop the run. The command memory sits outside the block. The block presents a word index on `cmd_addr_o` and reads the word back on `cmd_word_i` in the same cycle, so a ROM or register file filled at configuration time can hold the script.

Only one write is in flight at a time. The address and data channels are raised together, and each drops on its own ready. The next command is fetched only after the write response has been taken. Every write carries full byte strobes and a protection value of zero. A response other than OKAY sets a sticky error flag, and the script carries on. When the stop command is reached, `done_o` goes high and stays high until reset.

Top module: `axil_script_seq`

## Requirements
- R1: A command word holds an 8-bit opcode in bits [7:0] and a 32-bit operand in bits [39:8]. Commands are fetched from `cmd_addr_o` in ascending order, starting at index 0 after reset.
- R2: Opcode 0x01 copies the operand into the target address register in one cycle. The next command is fetched in the following cycle.
- R3: Opcode 0x0F issues one write: `m_awaddr_o` is the target address, `m_wdata_o` is the operand, `m_wstrb_o` is all ones and `m_awprot_o` is 0.
- R4: `m_awvalid_o` and `m_wvalid_o` rise in the same cycle. Each stays high, with its payload unchanged, until its own ready is seen, and then drops on its own.
- R5: `m_bready_o` rises only after both the address and the data have been accepted. The command after a write is fetched in the cycle after the B handshake, so two writes in a row give an address-valid rise one cycle after the first write's B handshake.
- R6: Opcode 0x07 with operand N ≥ 1 holds the sequencer for N cycles after the cycle in which it is fetched. With N = 0 it takes a single cycle.
- R7: The target address keeps its value across any number of writes until opcode 0x01 loads it again.
- R8: Opcode 0x00 stops the script. `done_o` goes high, `busy_o` goes low, `cmd_addr_o` stays on the stop word, and no further write is issued until reset.
- R9: Any other opcode is skipped in one cycle and has no effect on the port.
- R10: A B handshake with a response other than OKAY (0b00) sets `err_o`. The flag stays set until reset, and the script keeps running.
- R11: While reset is active, both valid outputs are low, `cmd_addr_o` is 0, `done_o` and `err_o` are 0 and `busy_o` is 1. The target address and the delay counter are cleared, so a write issued before any address load goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_addr_o | output | PC_W | Index of the command word being fetched |
| cmd_word_i | input | 40 | Command word at `cmd_addr_o`, read in the same cycle |
| m_awaddr_o | output | ADDR_W | Write address |
| m_awprot_o | output | 3 | Protection type, always 0 |
| m_awvalid_o | output | 1 | Write address valid |
| m_awready_i | input | 1 | Write address ready |
| m_wdata_o | output | 32 | Write data |
| m_wstrb_o | output | 4 | Byte strobes, all ones |
| m_wvalid_o | output | 1 | Write data valid |
| m_wready_i | input | 1 | Write data ready |
| m_bresp_i | input | 2 | Write response code |
| m_bvalid_i | input | 1 | Write response valid |
| m_bready_o | output | 1 | Write response ready |
| busy_o | output | 1 | High while the script is running |
| done_o | output | 1 | High after the stop command |
| err_o | output | 1 | Sticky flag for a response other than OKAY |

## Verification
The hardest part to reach from the ports is cycle-exact spacing between writes: a sleep, a skipped opcode or an address load can only be seen as the gap between one write's B handshake and the next address-valid rise. The bench builds a script that mixes back-to-back writes, sleeps of 5, 1 and 0 cycles, an unknown opcode and reloads. It predicts each gap from the requirements and measures it against a slave whose two ready lines accept address and data in shifting orders. One write gets an error response so the sticky flag can be seen while later writes still complete. The script is then run a second time after a reset, which checks that the address register clears and that nothing is issued past the stop word.

// File: rtl/axil_seq_pkg.sv
package axil_seq_pkg;
  localparam int OPC_W  = 8;
  localparam int OPND_W = 32;
  localparam int CMD_W  = OPND_W + OPC_W;

  localparam logic [OPC_W-1:0] OP_HALT  = 8'h00;
  localparam logic [OPC_W-1:0] OP_LOAD  = 8'h01;
  localparam logic [OPC_W-1:0] OP_SLEEP = 8'h07;
  localparam logic [OPC_W-1:0] OP_WRITE = 8'h0F;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_WRITE,
    ST_SLEEP,
    ST_HALT
  } seq_state_e;

  typedef struct packed {
    logic [OPND_W-1:0] operand;
    logic [OPC_W-1:0]  opcode;
  } cmd_t;
endpackage

// File: rtl/axil_seq_delay.sv
module axil_seq_delay #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_i;
    else if (run_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // R6
  cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q != '0));
endmodule

// File: rtl/axil_seq_wr.sv
module axil_seq_wr #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic [2:0]        awprot_o,
  output logic              awvalid_o,
  input  logic              awready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W/8-1:0] wstrb_o,
  output logic              wvalid_o,
  input  logic              wready_i,
  input  logic [1:0]        bresp_i,
  input  logic              bvalid_i,
  output logic              bready_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int STRB_W = DATA_W / 8;

  logic              aw_vld_q, w_vld_q, pend_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_vld_q <= 1'b0;
      w_vld_q  <= 1'b0;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      if (start_i) begin
        aw_vld_q <= 1'b1;
        w_vld_q  <= 1'b1;
        pend_q   <= 1'b1;
        addr_q   <= addr_i;
        data_q   <= data_i;
      end else begin
        if (aw_vld_q && awready_i) aw_vld_q <= 1'b0;
        if (w_vld_q && wready_i)   w_vld_q  <= 1'b0;
        if (done_o)                pend_q   <= 1'b0;
      end
      if (done_o && (bresp_i != 2'b00)) err_q <= 1'b1;
    end
  end

  // response accepted only once both request channels are through
  assign bready_o  = pend_q && !aw_vld_q && !w_vld_q;
  assign done_o    = bready_o && bvalid_i;
  assign awaddr_o  = addr_q;
  assign awprot_o  = 3'b000;
  assign awvalid_o = aw_vld_q;
  assign wdata_o   = data_q;
  assign wstrb_o   = {STRB_W{1'b1}};
  assign wvalid_o  = w_vld_q;
  assign err_o     = err_q;

  // R4
  aw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awvalid_o && !awready_i) |=> (awvalid_o && $stable(awaddr_o)));
  // R4
  w_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_o && !wready_i) |=> (wvalid_o && $stable(wdata_o)));
  // R4
  pair_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awvalid_o) |-> $rose(wvalid_o));
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/axil_script_seq.sv
module axil_script_seq
  import axil_seq_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  parameter int ADDR_W     = 32,
  localparam int PC_W      = $clog2(PROG_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   cmd_addr_o,
  input  logic [39:0]       cmd_word_i,
  output logic [ADDR_W-1:0] m_awaddr_o,
  output logic [2:0]        m_awprot_o,
  output logic              m_awvalid_o,
  input  logic              m_awready_i,
  output logic [31:0]       m_wdata_o,
  output logic [3:0]        m_wstrb_o,
  output logic              m_wvalid_o,
  input  logic              m_wready_i,
  input  logic [1:0]        m_bresp_i,
  input  logic              m_bvalid_i,
  output logic              m_bready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  cmd_t              cmd;
  seq_state_e        state_q, state_d;
  logic [PC_W-1:0]   pc_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              pc_inc, tgt_load, wr_start, wr_done, dly_load, dly_last;

  assign cmd = cmd_t'(cmd_word_i);

  always_comb begin
    state_d  = state_q;
    pc_inc   = 1'b0;
    tgt_load = 1'b0;
    wr_start = 1'b0;
    dly_load = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        case (cmd.opcode)
          OP_HALT:  state_d = ST_HALT;
          OP_LOAD: begin
            tgt_load = 1'b1;
            pc_inc   = 1'b1;
          end
          OP_WRITE: begin
            wr_start = 1'b1;
            state_d  = ST_WRITE;
          end
          OP_SLEEP: begin
            if (cmd.operand == '0) pc_inc = 1'b1;
            else begin
              dly_load = 1'b1;
              state_d  = ST_SLEEP;
            end
          end
          default:  pc_inc = 1'b1;
        endcase
      end
      ST_WRITE: if (wr_done) begin
        pc_inc  = 1'b1;
        state_d = ST_FETCH;
      end
      ST_SLEEP: if (dly_last) begin
        pc_inc  = 1'b1;
        state_d = ST_FETCH;
      end
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (pc_inc)   pc_q  <= pc_q + PC_W'(1);
      if (tgt_load) tgt_q <= cmd.operand[ADDR_W-1:0];
    end
  end

  axil_seq_delay #(.CNT_W(OPND_W)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dly_load),
    .len_i  (cmd.operand),
    .run_i  (state_q == ST_SLEEP),
    .last_o (dly_last)
  );

  axil_seq_wr #(.ADDR_W(ADDR_W), .DATA_W(OPND_W)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (wr_start),
    .addr_i    (tgt_q),
    .data_i    (cmd.operand),
    .awaddr_o  (m_awaddr_o),
    .awprot_o  (m_awprot_o),
    .awvalid_o (m_awvalid_o),
    .awready_i (m_awready_i),
    .wdata_o   (m_wdata_o),
    .wstrb_o   (m_wstrb_o),
    .wvalid_o  (m_wvalid_o),
    .wready_i  (m_wready_i),
    .bresp_i   (m_bresp_i),
    .bvalid_i  (m_bvalid_i),
    .bready_o  (m_bready_o),
    .done_o    (wr_done),
    .err_o     (err_o)
  );

  assign cmd_addr_o = pc_q;
  assign done_o     = (state_q == ST_HALT);
  assign busy_o     = !done_o;

  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(cmd_addr_o) && !m_awvalid_o));
  // R5
  fetch_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_awvalid_o || m_wvalid_o || (m_bready_o && !m_bvalid_i)) |=> $stable(cmd_addr_o));
endmodule

// File: tb/axil_script_seq_test.sv
module axil_script_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [3:0]  cmd_addr;
  logic [39:0] cmd_word;
  logic [31:0] awaddr, wdata;
  logic [2:0]  awprot;
  logic [3:0]  wstrb;
  logic        awvalid, wvalid, bready, busy, done, err;
  logic        s_awready = 1'b0, s_wready = 1'b0, s_bvalid = 1'b0;
  logic [1:0]  s_bresp = 2'b00;

  always #10 clk = ~clk;

  axil_script_seq #(.PROG_DEPTH(16), .ADDR_W(32)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_addr_o(cmd_addr), .cmd_word_i(cmd_word),
    .m_awaddr_o(awaddr), .m_awprot_o(awprot), .m_awvalid_o(awvalid), .m_awready_i(s_awready),
    .m_wdata_o(wdata), .m_wstrb_o(wstrb), .m_wvalid_o(wvalid), .m_wready_i(s_wready),
    .m_bresp_i(s_bresp), .m_bvalid_i(s_bvalid), .m_bready_o(bready),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  logic [39:0] prog [16];
  assign cmd_word = prog[cmd_addr];

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  logic [31:0] exp_addr[$], exp_data[$];
  int          exp_gap[$];
  bit          exp_err[$];
  string       exp_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic push_wr(input logic [31:0] a, input logic [31:0] d, input int gap,
                         input bit e, input string tag);
    exp_addr.push_back(a); exp_data.push_back(d); exp_gap.push_back(gap);
    exp_err.push_back(e);  exp_tag.push_back(tag);
  endtask

  function automatic logic [39:0] mk(input logic [7:0] op, input logic [31:0] opnd);
    return {opnd, op};
  endfunction

  task automatic load_expected();
    push_wr(32'h0000_0000, 32'h0000_0011, -1, 1'b0, "R11");
    push_wr(32'h0000_0010, 32'hA5A5_0001,  2, 1'b0, "R2");
    push_wr(32'h0000_0010, 32'h0000_0002,  1, 1'b0, "R5");
    push_wr(32'h0000_0024, 32'h1234_5678,  8, 1'b1, "R6");
    push_wr(32'h0000_0024, 32'hCAFE_0003,  3, 1'b0, "R9");
    push_wr(32'h0000_0004, 32'h0610_2010,  4, 1'b0, "R7");
  endtask

  // slave model and scoreboard monitor
  bit got_aw, got_w, b_prev, aw_prev, err_acc;
  int sp = 0, last_b = 0;
  always @(negedge clk) begin
    if (!rst_ni) begin
      got_aw = 0; got_w = 0; b_prev = 0; aw_prev = 0;
      s_bvalid = 1'b0; s_awready = 1'b0; s_wready = 1'b0;
    end else begin
      sp++;
      if (b_prev) begin
        s_bvalid = 1'b0; b_prev = 0;
        chk(err == err_acc, "R10", "err flag after response", {31'd0, err}, {31'd0, err_acc});
      end
      if (got_aw && got_w && !s_bvalid) begin
        s_bvalid = 1'b1;
        s_bresp  = (exp_addr.size() > 0 && exp_err[0]) ? 2'b10 : 2'b00;
      end
      if (s_bvalid && bready) begin
        b_prev = 1; last_b = cyc + 1; got_aw = 0; got_w = 0;
        if (exp_addr.size() > 0) begin
          err_acc = err_acc | exp_err[0];
          void'(exp_addr.pop_front()); void'(exp_data.pop_front());
          void'(exp_gap.pop_front());  void'(exp_err.pop_front());
          void'(exp_tag.pop_front());
        end
      end
      if (awvalid && !aw_prev) begin
        if (exp_addr.size() == 0)
          chk(1'b0, "R8", "write issued with none expected", awaddr, 32'h0);
        else begin
          chk(wvalid, "R4", "wvalid rises with awvalid", {31'd0, wvalid}, 32'd1);
          if (exp_gap[0] >= 0)
            chk((cyc - last_b) == exp_gap[0], exp_tag[0], "cycles from B to next write",
                cyc - last_b, exp_gap[0]);
        end
      end
      aw_prev = awvalid;
      s_awready = got_aw ? 1'b0 : ((sp % 3) != 1);
      s_wready  = got_w  ? 1'b0 : ((sp % 4) != 0);
      if (awvalid && s_awready && !got_aw) begin
        got_aw = 1;
        if (exp_addr.size() > 0) begin
          chk(awaddr == exp_addr[0], exp_tag[0], "write address", awaddr, exp_addr[0]);
          chk(awprot == 3'b000, "R3", "awprot", {29'd0, awprot}, 32'd0);
        end
      end
      if (wvalid && s_wready && !got_w) begin
        got_w = 1;
        if (exp_addr.size() > 0) begin
          chk(wdata == exp_data[0], "R3", "write data", wdata, exp_data[0]);
          chk(wstrb == 4'hF, "R3", "write strobes", {28'd0, wstrb}, 32'hF);
        end
      end
    end
  end

  task automatic run_to_halt();
    while (!done) @(negedge clk);
    chk(cmd_addr == 4'd13, "R1", "fetch index at stop", {28'd0, cmd_addr}, 32'd13);
    chk(!busy, "R8", "busy after stop", {31'd0, busy}, 32'd0);
    chk(exp_addr.size() == 0, "R5", "writes left over", exp_addr.size(), 32'd0);
    repeat (40) @(negedge clk);
    chk(done && cmd_addr == 4'd13, "R8", "stop held", {28'd0, cmd_addr}, 32'd13);
    chk(!awvalid, "R8", "no write after stop", {31'd0, awvalid}, 32'd0);
  endtask

  initial begin
    prog[0]  = mk(8'h0F, 32'h0000_0011);
    prog[1]  = mk(8'h01, 32'h0000_0010);
    prog[2]  = mk(8'h0F, 32'hA5A5_0001);
    prog[3]  = mk(8'h0F, 32'h0000_0002);
    prog[4]  = mk(8'h07, 32'd5);
    prog[5]  = mk(8'h01, 32'h0000_0024);
    prog[6]  = mk(8'h0F, 32'h1234_5678);
    prog[7]  = mk(8'h07, 32'd0);
    prog[8]  = mk(8'h33, 32'h0000_DEAD);
    prog[9]  = mk(8'h0F, 32'hCAFE_0003);
    prog[10] = mk(8'h07, 32'd1);
    prog[11] = mk(8'h01, 32'h0000_0004);
    prog[12] = mk(8'h0F, 32'h0610_2010);
    prog[13] = mk(8'h00, 32'h0);
    prog[14] = mk(8'h0F, 32'h0000_0BAD);
    prog[15] = mk(8'h00, 32'h0);
    rst_ni  = 1'b0;
    err_acc = 0;
    load_expected();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!awvalid && !wvalid, "R11", "valids in reset", {30'd0, awvalid, wvalid}, 32'd0);
    chk(cmd_addr == 4'd0, "R11", "fetch index in reset", {28'd0, cmd_addr}, 32'd0);
    chk(!done && !err && busy, "R11", "status in reset", {29'd0, done, err, busy}, 32'd1);
    rst_ni = 1'b1;
    run_to_halt();
    // second run after reset: address register and error flag must clear
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!err && !done && cmd_addr == 4'd0, "R11", "status after rerun reset",
        {28'd0, cmd_addr}, 32'd0);
    err_acc = 0;
    load_expected();
    @(negedge clk);
    rst_ni = 1'b1;
    run_to_halt();
    chk(err, "R10", "error flag held to end", {31'd0, err}, 32'd1);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected halt");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule